// File: doc/BRIEF.md
# External Bus Write Cycle Sequencer

This block turns a single internal write request into a write cycle on an 8-bit-style external bus. It runs from a system clock that is faster than the bus. A request carries an address, a data byte and a flag that selects a memory transfer or an I/O transfer. It is accepted only while the sequencer is idle. The cycle then passes through three bus phases. In the first phase the address, data and chip select come out. In the second phase the write strobe and the selected request strobe are pulled low. In the third phase everything is held. After that, all strobes are released and a one-clock completion pulse is given.

Each bus phase lasts a programmable number N of system clocks, set by a 4-bit length value; a value of zero acts as one. A slow peripheral can stretch the cycle by pulling the active-low wait input. That input is synchronised with two flops. When its synchronised value is low during the last clock of the second phase, a wait phase of N clocks is added. The same test is made at the end of each wait phase, so wait phases repeat until the line is seen high.

All strobes are active-low and driven straight from flops. Address and data are captured when the request is accepted and held for the whole cycle.

Top module: `xbus_wr_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a cycle is running, `req_ready` is low and changes on the request inputs do not alter the bus outputs.
- R2: The phase length N equals `phase_len`, with 0 treated as 1. It is captured when the request is accepted, so a later change of `phase_len` has no effect on the running cycle.
- R3: Counting the clock in which the request is presented as cycle 0, `bus_cs_n` goes low in cycle 1. For cycles 1..N (the first phase), `bus_wr_n`, `bus_mreq_n` and `bus_iorq_n` stay high.
- R4: From cycle N+1, `bus_wr_n` is low together with `bus_mreq_n` when `req_is_io` was 0, or with `bus_iorq_n` when it was 1. The other request strobe stays high, and `bus_wr_n` is never low while `bus_cs_n` is high.
- R5: The level of `wait_n` during cycle c is what the sequencer sees during cycle c+2. If that seen value is low in the last clock of the second phase or of a wait phase, one more wait phase of N clocks follows. The number of wait phases W is therefore the smallest j ≥ 0 for which `wait_n` is high during cycle (2+j)·N−2.
- R6: During the third phase (the N clocks after the second phase and any wait phases), no bus output changes.
- R7: In cycle 3N+W·N+1, all four strobes are high and `done` is high for exactly that one clock. `bus_cs_n` is low for 3N+W·N clocks in total, and `bus_wr_n` with the selected request strobe is low for 2N+W·N clocks.
- R8: While `bus_cs_n` is low, `bus_addr` and `bus_data` equal the accepted request's address and data and do not change.
- R9: `req_ready` is already high in the `done` cycle. A request presented there is accepted, and its first phase (with its own address) begins in the next cycle.
- R10: During and right after reset, all strobes are high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request write data |
| req_is_io | input | 1 | 1 selects an I/O transfer, 0 a memory transfer |
| phase_len | input | LEN_W | System clocks per bus phase (0 acts as 1) |
| wait_n | input | 1 | Asynchronous active-low wait request from the bus |
| bus_addr | output | ADDR_W | External address |
| bus_data | output | DATA_W | External write data |
| bus_cs_n | output | 1 | Chip select, active-low |
| bus_wr_n | output | 1 | Write strobe, active-low |
| bus_mreq_n | output | 1 | Memory request strobe, active-low |
| bus_iorq_n | output | 1 | I/O request strobe, active-low |
| done | output | 1 | One-clock pulse after a cycle completes |

## Verification
The completion pulse of one cycle and the acceptance of the next request can fall in the same clock. This is because `req_ready` already rises in the `done` cycle. The bench provokes this by holding `req_valid` high, with a second address and data, across the whole of a short cycle. It then checks that `done` and `req_ready` are both high in that clock, that the strobes are high there, and that the next clock already shows chip select low with the second address. A second run keeps `req_valid` and a changed `phase_len` asserted only until the clock before `done`, and checks that the cycle length does not change and that no further cycle starts.

// File: rtl/xbus_wr_pkg.sv
package xbus_wr_pkg;

   // Bus phases of one write cycle; TW is an inserted wait phase.
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_TW   = 3'd3,
      PH_T3   = 3'd4
   } bus_phase_e;

   // Chip select is held in every active phase.
   function automatic logic phase_holds_cs(bus_phase_e p);
      return p != PH_IDLE;
   endfunction

   // Write and request strobes are held from the second phase onward.
   function automatic logic phase_holds_wr(bus_phase_e p);
      return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
   endfunction

endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xbus_wait_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RESET_VAL;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RESET_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   output logic             last
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_len - LEN_W'(1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - LEN_W'(1);
   end

   assign last = (cnt_q == '0);

   // The length fed in must already be clamped to at least one (R2).
   p_load_nonzero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_len != '0));

   // A freshly loaded phase of length > 1 is not immediately at its end (R2).
   p_long_phase_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_len > LEN_W'(1)) |=> !last);

endmodule

// File: rtl/xbus_wr_ctrl.sv
module xbus_wr_ctrl
   import xbus_wr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_io,
   input  logic phase_last,
   input  logic wait_ok,
   output logic timer_load,
   output logic idle,
   output logic cs_n,
   output logic wr_n,
   output logic mreq_n,
   output logic iorq_n,
   output logic done
);

   bus_phase_e state_q, state_d;
   logic       io_q, io_next;

   always_comb begin
      state_d    = state_q;
      timer_load = 1'b0;
      unique case (state_q)
         PH_IDLE: if (start) begin
            state_d    = PH_T1;
            timer_load = 1'b1;
         end
         PH_T1: if (phase_last) begin
            state_d    = PH_T2;
            timer_load = 1'b1;
         end
         PH_T2, PH_TW: if (phase_last) begin
            state_d    = wait_ok ? PH_T3 : PH_TW;
            timer_load = 1'b1;
         end
         PH_T3: if (phase_last) state_d = PH_IDLE;
         default: state_d = PH_IDLE;
      endcase
   end

   assign io_next = (start && state_q == PH_IDLE) ? is_io : io_q;
   assign idle    = (state_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         io_q    <= 1'b0;
         cs_n    <= 1'b1;
         wr_n    <= 1'b1;
         mreq_n  <= 1'b1;
         iorq_n  <= 1'b1;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         io_q    <= io_next;
         cs_n    <= !phase_holds_cs(state_d);
         wr_n    <= !phase_holds_wr(state_d);
         mreq_n  <= !(phase_holds_wr(state_d) && !io_next);
         iorq_n  <= !(phase_holds_wr(state_d) &&  io_next);
         done    <= (state_q == PH_T3) && phase_last;
      end
   end

   // Third phase leaves every strobe untouched (R6).
   p_t3_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_T3 && $past(state_q) == PH_T3)
         |-> $stable({cs_n, wr_n, mreq_n, iorq_n}));

   // Wait phases only follow the second phase or another wait phase (R5).
   p_tw_entry_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_TW && $past(state_q) != PH_TW) |-> $past(state_q) == PH_T2);

   // A wait phase is entered only when the synchronised line was low (R5).
   p_tw_needs_wait_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PH_T2 || state_q == PH_TW) && phase_last && wait_ok)
         |=> state_q == PH_T3);

endmodule

// File: rtl/xbus_wr_seq.sv
module xbus_wr_seq
   import xbus_wr_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int LEN_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_is_io,
   input  logic [LEN_W-1:0]  phase_len,
   input  logic              wait_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_cs_n,
   output logic              bus_wr_n,
   output logic              bus_mreq_n,
   output logic              bus_iorq_n,
   output logic              done
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("xbus_wr_seq: ADDR_W and DATA_W must be positive");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("xbus_wr_seq: LEN_W must be 1..8");
   end

   logic             idle, start, timer_load, phase_last, wait_ok;
   logic [LEN_W-1:0] len_eff, len_q, timer_len;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign start     = req_valid && idle;
   assign req_ready = idle;
   assign len_eff   = (phase_len == '0) ? LEN_ONE : phase_len;
   assign timer_len = start ? len_eff : len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= LEN_ONE;
         addr_q <= '0;
         data_q <= '0;
      end else if (start) begin
         len_q  <= len_eff;
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

   assign bus_addr = addr_q;
   assign bus_data = data_q;

   xbus_wait_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (wait_n),
      .q_sync  (wait_ok)
   );

   xbus_phase_timer #(.LEN_W(LEN_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_len (timer_len),
      .last     (phase_last)
   );

   xbus_wr_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_io      (req_is_io),
      .phase_last (phase_last),
      .wait_ok    (wait_ok),
      .timer_load (timer_load),
      .idle       (idle),
      .cs_n       (bus_cs_n),
      .wr_n       (bus_wr_n),
      .mreq_n     (bus_mreq_n),
      .iorq_n     (bus_iorq_n),
      .done       (done)
   );

   // Idle means no chip select on the bus (R1).
   p_ready_bus_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> bus_cs_n);

   // Write strobe only inside chip select (R4).
   p_wr_in_cs_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !bus_cs_n);

   // Never both request strobes at once (R4).
   p_one_request_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_mreq_n && !bus_iorq_n));

   // A request strobe always comes with the write strobe (R4).
   p_req_with_wr_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_mreq_n || !bus_iorq_n) |-> !bus_wr_n);

   // Address and data frozen while selected (R8).
   p_addr_stable_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

   // Completion pulse comes with every strobe released (R7).
   p_done_released_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_cs_n && bus_wr_n && bus_mreq_n && bus_iorq_n));

   // Completion pulse lasts one clock (R7).
   p_done_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // Completion pulse leaves the block ready (R9).
   p_done_ready_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

// File: tb/xbus_wr_seq_bench.sv
module xbus_wr_seq_bench;

   localparam int CLK_P = 10;
   localparam int AW    = 16;
   localparam int DW    = 8;
   localparam int NV    = 10;

   // Vector table: phase length, I/O flag, last cycle wait_n is held low (-1: never).
   localparam int V_LEN [NV] = '{3, 1, 0, 15, 2, 2, 1, 3, 3, 15};
   localparam int V_IO  [NV] = '{0, 1, 0,  1, 1, 0, 1, 0, 0,  0};
   localparam int V_LW  [NV] = '{-1,-1,-1,-1, 0, 2, 5, 3, 4, 40};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_is_io = 1'b0;
   logic [3:0]    phase_len = 4'd1;
   logic          wait_n = 1'b1;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic          bus_cs_n, bus_wr_n, bus_mreq_n, bus_iorq_n, done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   xbus_wr_seq u_xbus_wr_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_is_io(req_is_io),
      .phase_len(phase_len), .wait_n(wait_n), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
      .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // One write cycle; req_valid is kept high (with the second address/data/length)
   // through cycle 'hold' counted from the acceptance clock 0.
   task automatic run_txn(input int len, input bit io, input int lw,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int hold, input logic [AW-1:0] a2,
                          input logic [DW-1:0] d2, input int len2);
      int n, w, e;
      int cs_cnt, cs_first, wr_cnt, wr_first, mr_cnt, io_cnt, done_cnt, done_at;
      int bad_ad, rdy_bad, rdy_end, t3_chg;
      logic [3:0] t3_prev;
      n = (len == 0) ? 1 : len;
      w = 0;
      while ((2 + w) * n - 2 <= lw) w++;
      e = 3 * n + w * n;
      cs_cnt = 0; cs_first = 0; wr_cnt = 0; wr_first = 0; mr_cnt = 0; io_cnt = 0;
      done_cnt = 0; done_at = 0; bad_ad = 0; rdy_bad = 0; rdy_end = 0; t3_chg = 0;
      t3_prev = 4'h0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready while idle", int'(req_ready), 1);
      req_valid = 1'b1; req_addr = a; req_data = d; req_is_io = io;
      phase_len = 4'(len); wait_n = (0 > lw);
      for (int k = 1; k <= e + 1; k++) begin
         @(negedge clk);
         if (k == 1 && hold >= 1) begin
            req_addr = a2; req_data = d2; phase_len = 4'(len2); req_is_io = !io;
         end
         if (k > hold) req_valid = 1'b0;
         wait_n = (k > lw);
         if (!bus_cs_n) begin
            cs_cnt++;
            if (cs_first == 0) cs_first = k;
            if (bus_addr !== a || bus_data !== d) bad_ad++;
         end
         if (!bus_wr_n) begin
            wr_cnt++;
            if (wr_first == 0) wr_first = k;
         end
         if (!bus_mreq_n) mr_cnt++;
         if (!bus_iorq_n) io_cnt++;
         if (done) begin done_cnt++; done_at = k; end
         if (k <= e && req_ready) rdy_bad++;
         if (k == e + 1) rdy_end = int'(req_ready);
         if (k > e - n + 1 && k <= e) begin
            if ({bus_cs_n, bus_wr_n, bus_mreq_n, bus_iorq_n} !== t3_prev) t3_chg++;
         end
         t3_prev = {bus_cs_n, bus_wr_n, bus_mreq_n, bus_iorq_n};
      end
      chk(cs_first == 1, "R3 chip select first low cycle", cs_first, 1);
      chk(wr_first == n + 1, "R4 write strobe first low cycle (R2 length)", wr_first, n + 1);
      chk(cs_cnt == e, "R7 chip select low cycles (R5 waits)", cs_cnt, e);
      chk(wr_cnt == 2 * n + w * n, "R5 write strobe low cycles", wr_cnt, 2 * n + w * n);
      chk((io ? io_cnt : mr_cnt) == 2 * n + w * n, "R4 selected request strobe cycles",
          io ? io_cnt : mr_cnt, 2 * n + w * n);
      chk((io ? mr_cnt : io_cnt) == 0, "R4 other request strobe stays high",
          io ? mr_cnt : io_cnt, 0);
      chk(done_cnt == 1 && done_at == e + 1, "R7 done position", done_at, e + 1);
      chk(bad_ad == 0, "R8 address and data held", bad_ad, 0);
      chk(t3_chg == 0, "R6 third phase outputs unchanged", t3_chg, 0);
      chk(rdy_bad == 0, "R1 ready low while busy", rdy_bad, 0);
      chk(rdy_end == 1, "R9 ready in done cycle", rdy_end, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int b2b_cs;
      // R10: reset state
      repeat (2) @(negedge clk);
      chk(bus_cs_n && bus_wr_n && bus_mreq_n && bus_iorq_n, "R10 strobes high in reset",
          int'({bus_cs_n, bus_wr_n, bus_mreq_n, bus_iorq_n}), 15);
      chk(done == 1'b0, "R10 done low in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && bus_cs_n && !done, "R10 idle after reset",
          int'({req_ready, bus_cs_n, done}), 6);

      // Table of vectors, one loop
      for (int i = 0; i < NV; i++) begin
         run_txn(V_LEN[i], V_IO[i][0], V_LW[i], AW'(16'h1000 + i * 16'h0111),
                 DW'(8'h5A ^ i), 0, '0, '0, 0);
         wait_n = 1'b1;
         repeat (3) @(negedge clk);
      end

      // R1 / R2: requests and a new length while busy are ignored
      run_txn(2, 1'b0, -1, 16'hA55A, 8'hC3, 6, 16'h0F0F, 8'h3C, 7);
      repeat (3) @(negedge clk);
      chk(bus_cs_n == 1'b1 && req_ready == 1'b1, "R1 no extra cycle after busy request",
          int'({bus_cs_n, req_ready}), 3);

      // R9: back-to-back acceptance in the done cycle
      run_txn(1, 1'b1, -1, 16'h2222, 8'h11, 1000, 16'h3333, 8'h22, 2);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!bus_cs_n && bus_addr == 16'h3333, "R9 next cycle starts after done",
          int'(bus_addr), 16'h3333);
      b2b_cs = 1;
      for (int k = 0; k < 20 && !done; k++) begin
         @(negedge clk);
         if (!bus_cs_n) b2b_cs++;
      end
      chk(b2b_cs == 6, "R2 second cycle uses its own length", b2b_cs, 6);
      chk(done == 1'b1, "R7 second cycle completes", int'(done), 1);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule